// File: doc/BRIEF.md
# Multithreaded Commit Slot Arbiter

This block decides, slot by slot, which hardware thread may retire the instruction at the head of its reorder buffer. A commit round begins with a one-cycle start pulse. In each slot the arbiter judges every thread on four inputs: its commit status code, a reorder-buffer-empty flag, a head-ready flag and the sequence number of its head instruction. It then grants one thread and waits for the retire logic to acknowledge that retirement. After the acknowledgement it judges the threads again on their refreshed inputs. The round stops when the configured commit width is used up, when no thread qualifies, or when the chosen thread's head is not ready.

A static policy input chooses the selection rule. Oldest-ready and greedy grant the eligible thread whose ready head is oldest. Rotating walks a priority list that starts in ascending thread order and sends each winner to the tail. The block keeps a per-round count of retirements for the pipeline's bookkeeping. The retirement itself, rename updates and fault handling sit outside this block.

The control is a four-state machine:
- `SL_IDLE` waits for a start pulse.
- `SL_SELECT` evaluates one slot. It goes to `SL_WAIT_ACK` on a grant, or to `SL_DONE` when there is nothing to grant.
- `SL_WAIT_ACK` holds the grant until the acknowledgement arrives, then returns to `SL_SELECT`.
- `SL_DONE` flags the end of the round for one cycle and returns to `SL_IDLE`.

Top module: `commit_slot_arb`

## Requirements
- R1: After reset, grant_valid, round_done and retire_count are 0, and the rotating priority list holds the thread ids in ascending order (0 first).
- R2: A round_start pulse while idle starts a round. Each grant holds grant_valid high until retire_ack. The round ends with a single-cycle round_done pulse once no further grant can be made.
- R3: retire_count is cleared at round_start and rises by one per acknowledged grant. It never exceeds WIDTH, and a round stops granting once WIDTH grants have been acknowledged. The value is held after round_done until the next start.
- R4: Oldest-ready policy (policy_sel = 2, and also 3): a thread is eligible when its reorder buffer is not empty, its head is ready, and its status is running (0), idle (1) or fetch-trap-waiting (4). Squashing (2) and trap-waiting (3) exclude it. Among eligible threads, the smallest head sequence number wins, with ties going to the lowest thread id.
- R5: Greedy policy (policy_sel = 0) uses the same eligibility and ordering as R4 in every slot.
- R6: Rotating policy (policy_sel = 1) grants the first thread in priority-list order whose head is ready and whose status is running (0) or idle (1). It ignores the empty flag and sequence numbers. The winner moves to the tail of the list.
- R7: The priority list changes only when a thread wins under the rotating policy, and it persists across rounds.
- R8: With a single configured thread, that thread is selected whenever its status is 0, 1 or 4, whatever its empty flag. It is granted only if its head is ready.
- R9: Each slot judges the threads on the inputs present after the previous slot's acknowledgement, so a thread may win several slots of one round while its head stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy_sel | input | 2 | 0 greedy, 1 rotating, 2/3 oldest-ready |
| round_start | input | 1 | Begins a commit round when idle |
| thr_status | input | NT*3 | Per-thread status code, thread t at bits [3t+2:3t] |
| rob_empty | input | NT | Per-thread reorder buffer empty |
| head_ready | input | NT | Per-thread head instruction ready to retire |
| head_seq | input | NT*SEQW | Per-thread head sequence number |
| retire_ack | input | 1 | Acknowledges the current grant |
| grant_valid | output | 1 | A thread is granted in this slot |
| grant_tid | output | TIDW | Granted thread id |
| retire_count | output | CNTW | Retirements made in the current round |
| round_done | output | 1 | One-cycle end-of-round flag |

## Verification
On every cycle, the embedded properties check the following: each new grant names a thread that was ready and in a committing status the cycle before; the count stays within WIDTH and steps by one per acknowledgement; round_done lasts a single cycle; and the priority list is always a permutation of the thread ids. The grant order itself can only be shown by the directed rounds. That covers oldest-first with tie-breaking, the rotating list moving winners to the tail and persisting across rounds, exclusion by status and empty flag, saturation at the width, and the single-thread rules.

// File: rtl/cts_pkg.sv
package cts_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_IDLE       = 3'd1,
        ST_SQUASH     = 3'd2,
        ST_TRAP_WAIT  = 3'd3,
        ST_FTRAP_WAIT = 3'd4
    } thr_stat_e;

    typedef enum logic [1:0] {
        POL_GREEDY = 2'd0,
        POL_ROTATE = 2'd1,
        POL_OLDEST = 2'd2
    } pol_e;

    typedef enum logic [1:0] {
        SL_IDLE,
        SL_SELECT,
        SL_WAIT_ACK,
        SL_DONE
    } slot_state_e;

    // status codes that may take part in rotating selection
    function automatic logic may_commit_rot(input logic [2:0] s);
        return (s == ST_RUN) || (s == ST_IDLE);
    endfunction

    // status codes that may take part in age-based selection
    function automatic logic may_commit_age(input logic [2:0] s);
        return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_FTRAP_WAIT);
    endfunction

endpackage

// File: rtl/cts_age_pick.sv
module cts_age_pick #(
    parameter int NT   = 4,
    parameter int SEQW = 8,
    parameter int TIDW = 2
) (
    input  logic [NT*3-1:0]    status,
    input  logic [NT-1:0]      empty,
    input  logic [NT-1:0]      ready,
    input  logic [NT*SEQW-1:0] seq,
    output logic               found,
    output logic [TIDW-1:0]    tid
);
    logic [SEQW-1:0] best;

    // strict less-than keeps the lowest id on equal ages
    always_comb begin
        found = 1'b0;
        tid   = '0;
        best  = '0;
        for (int t = 0; t < NT; t++) begin
            if (!empty[t] && ready[t] &&
                cts_pkg::may_commit_age(status[t*3 +: 3])) begin
                if (!found || (seq[t*SEQW +: SEQW] < best)) begin
                    found = 1'b1;
                    tid   = TIDW'(t);
                    best  = seq[t*SEQW +: SEQW];
                end
            end
        end
    end
endmodule

// File: rtl/cts_rot_list.sv
module cts_rot_list #(
    parameter int NT   = 4,
    parameter int TIDW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NT*3-1:0] status,
    input  logic [NT-1:0]   ready,
    input  logic            rotate,
    output logic            found,
    output logic [TIDW-1:0] tid
);
    localparam int POSW = (NT > 1) ? $clog2(NT) : 1;

    logic [TIDW-1:0] prio_q [NT];
    logic [POSW-1:0] pos;

    // first qualifying thread in list order
    always_comb begin
        found = 1'b0;
        tid   = '0;
        pos   = '0;
        for (int i = 0; i < NT; i++) begin
            if (!found && ready[prio_q[i]] &&
                cts_pkg::may_commit_rot(status[prio_q[i]*3 +: 3])) begin
                found = 1'b1;
                tid   = prio_q[i];
                pos   = POSW'(i);
            end
        end
    end

    // winner leaves its place, later entries close up, winner goes last
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) prio_q[i] <= TIDW'(i);
        end else if (rotate && found) begin
            for (int i = 0; i < NT; i++) begin
                if (i == NT - 1)
                    prio_q[i] <= tid;
                else if (POSW'(i) >= pos)
                    prio_q[i] <= prio_q[i+1];
            end
        end
    end

    logic [NT-1:0] seen_mask;
    always_comb begin
        seen_mask = '0;
        for (int i = 0; i < NT; i++) seen_mask[prio_q[i]] = 1'b1;
    end

    AST_ORDER_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen_mask) == NT); // R7
endmodule

// File: rtl/cts_slot_fsm.sv
module cts_slot_fsm #(
    parameter int WIDTH = 4,
    parameter int TIDW  = 2,
    parameter int CNTW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            pick_found,
    input  logic            pick_ready,
    input  logic [TIDW-1:0] pick_tid,
    input  logic            ack,
    output logic            launch,
    output logic            grant_valid,
    output logic [TIDW-1:0] grant_tid,
    output logic [CNTW-1:0] count,
    output logic            done
);
    import cts_pkg::*;

    slot_state_e state_q, state_d;
    logic [TIDW-1:0] tid_q;
    logic [CNTW-1:0] cnt_q;
    logic            room;

    assign room   = cnt_q < CNTW'(WIDTH);
    assign launch = (state_q == SL_SELECT) && room && pick_found && pick_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_IDLE:     if (start) state_d = SL_SELECT;
            SL_SELECT:   state_d = launch ? SL_WAIT_ACK : SL_DONE;
            SL_WAIT_ACK: if (ack) state_d = SL_SELECT;
            SL_DONE:     state_d = SL_IDLE;
            default:     state_d = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tid_q <= '0;
            cnt_q <= '0;
        end else begin
            if (state_q == SL_IDLE && start) cnt_q <= '0;
            if (launch) tid_q <= pick_tid;
            if (state_q == SL_WAIT_ACK && ack && room) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        grant_valid = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            SL_WAIT_ACK: grant_valid = 1'b1;
            SL_DONE:     done        = 1'b1;
            default:     ;
        endcase
        grant_tid = tid_q;
        count     = cnt_q;
    end

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(WIDTH)); // R3
    AST_ACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && ack) |=> (count == $past(count) + 1'b1)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
endmodule

// File: rtl/commit_slot_arb.sv
module commit_slot_arb #(
    parameter int NT    = 4,
    parameter int WIDTH = 4,
    parameter int SEQW  = 8,
    parameter int TIDW  = (NT > 1) ? $clog2(NT) : 1,
    parameter int CNTW  = $clog2(WIDTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         policy_sel,
    input  logic               round_start,
    input  logic [NT*3-1:0]    thr_status,
    input  logic [NT-1:0]      rob_empty,
    input  logic [NT-1:0]      head_ready,
    input  logic [NT*SEQW-1:0] head_seq,
    input  logic               retire_ack,
    output logic               grant_valid,
    output logic [TIDW-1:0]    grant_tid,
    output logic [CNTW-1:0]    retire_count,
    output logic               round_done
);
    import cts_pkg::*;

    logic            pick_found;
    logic [TIDW-1:0] pick_tid;
    logic            pick_ready;
    logic            launch;

    generate
        if (NT == 1) begin : g_single
            assign pick_found = may_commit_age(thr_status[2:0]);
            assign pick_tid   = '0;
            logic unused_single;
            assign unused_single = ^{policy_sel, rob_empty, head_seq, launch};
        end else begin : g_multi
            logic            age_found, rot_found;
            logic [TIDW-1:0] age_tid, rot_tid;
            logic            use_rot;
            assign use_rot = (policy_sel == POL_ROTATE);

            cts_age_pick #(.NT(NT), .SEQW(SEQW), .TIDW(TIDW)) u_age (
                .status(thr_status), .empty(rob_empty), .ready(head_ready),
                .seq(head_seq), .found(age_found), .tid(age_tid));

            cts_rot_list #(.NT(NT), .TIDW(TIDW)) u_rot (
                .clk(clk), .rst_n(rst_n), .status(thr_status),
                .ready(head_ready), .rotate(launch && use_rot),
                .found(rot_found), .tid(rot_tid));

            assign pick_found = use_rot ? rot_found : age_found;
            assign pick_tid   = use_rot ? rot_tid   : age_tid;
        end
    endgenerate

    assign pick_ready = head_ready[pick_tid];

    cts_slot_fsm #(.WIDTH(WIDTH), .TIDW(TIDW), .CNTW(CNTW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(round_start),
        .pick_found(pick_found), .pick_ready(pick_ready), .pick_tid(pick_tid),
        .ack(retire_ack), .launch(launch), .grant_valid(grant_valid),
        .grant_tid(grant_tid), .count(retire_count), .done(round_done));

    logic [NT-1:0]   ready_d;
    logic [NT*3-1:0] status_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_d  <= '0;
            status_d <= '0;
        end else begin
            ready_d  <= head_ready;
            status_d <= thr_status;
        end
    end

    AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ready_d[grant_tid]); // R4
    AST_GRANT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> may_commit_age(status_d[grant_tid*3 +: 3])); // R6
endmodule

// File: tb/sim_commit_slot_arb.sv
module sim_commit_slot_arb;
    localparam int NT = 4, WIDTH = 4, SEQW = 8, TIDW = 2, CNTW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]         policy_sel = 2'd2;
    logic               round_start = 1'b0;
    logic [NT*3-1:0]    thr_status = '0;
    logic [NT-1:0]      rob_empty = '0;
    logic [NT-1:0]      head_ready = '0;
    logic [NT*SEQW-1:0] head_seq = '0;
    logic               retire_ack = 1'b0;
    logic               grant_valid;
    logic [TIDW-1:0]    grant_tid;
    logic [CNTW-1:0]    retire_count;
    logic               round_done;

    commit_slot_arb #(.NT(NT), .WIDTH(WIDTH), .SEQW(SEQW)) u0 (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
        .round_start(round_start), .thr_status(thr_status),
        .rob_empty(rob_empty), .head_ready(head_ready), .head_seq(head_seq),
        .retire_ack(retire_ack), .grant_valid(grant_valid),
        .grant_tid(grant_tid), .retire_count(retire_count),
        .round_done(round_done));

    // single-thread instance
    logic       s_start = 1'b0, s_ack = 1'b0;
    logic [2:0] s_status = 3'd0;
    logic       s_empty = 1'b0, s_ready = 1'b0;
    logic       s_gv, s_done;
    logic [0:0] s_tid;
    logic [1:0] s_cnt;

    commit_slot_arb #(.NT(1), .WIDTH(2), .SEQW(SEQW)) u1 (
        .clk(clk), .rst_n(rst_n), .policy_sel(2'd1), .round_start(s_start),
        .thr_status(s_status), .rob_empty(s_empty), .head_ready(s_ready),
        .head_seq(8'd0), .retire_ack(s_ack), .grant_valid(s_gv),
        .grant_tid(s_tid), .retire_count(s_cnt), .round_done(s_done));

    int total = 0, bad = 0;
    int cnt [NT];
    int seqv [NT];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_heads();
        for (int t = 0; t < NT; t++) begin
            head_ready[t] = cnt[t] > 0;
            head_seq[t*SEQW +: SEQW] = SEQW'(seqv[t]);
        end
    endtask

    task automatic set_status(input int s0, input int s1, input int s2, input int s3);
        thr_status = {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
    endtask

    task automatic set_heads(input int c0, input int c1, input int c2, input int c3,
                             input int q0, input int q1, input int q2, input int q3);
        cnt[0] = c0; cnt[1] = c1; cnt[2] = c2; cnt[3] = c3;
        seqv[0] = q0; seqv[1] = q1; seqv[2] = q2; seqv[3] = q3;
        drive_heads();
    endtask

    // one commit round; the bench retires one instruction per grant
    task automatic run_round(input string req, input int n_exp,
                             input int e0, input int e1, input int e2, input int e3);
        int got [8];
        int ng = 0;
        bit finished = 0;
        int ex [4];
        ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
        @(negedge clk) round_start = 1'b1;
        @(negedge clk) round_start = 1'b0;
        for (int k = 0; k < 60 && !finished; k++) begin
            @(negedge clk);
            if (grant_valid) begin
                if (ng < 8) got[ng] = int'(grant_tid);
                ng++;
                cnt[grant_tid]--;
                seqv[grant_tid] += 4;
                drive_heads();
                retire_ack = 1'b1;
                @(negedge clk) retire_ack = 1'b0;
            end else if (round_done) begin
                finished = 1;
            end
        end
        check(finished, {req, " round ends with round_done"}, int'(finished), 1);
        check(ng == n_exp, {req, " grant count"}, ng, n_exp);
        for (int i = 0; i < n_exp && i < 4 && i < ng; i++)
            check(got[i] == ex[i], {req, " grant order"}, got[i], ex[i]);
        check(int'(retire_count) == n_exp, {req, " retire_count"}, int'(retire_count), n_exp);
    endtask

    task automatic t_reset();
        check(grant_valid == 1'b0, "R1 grant_valid", int'(grant_valid), 0);
        check(round_done == 1'b0, "R1 round_done", int'(round_done), 0);
        check(retire_count == 0, "R1 retire_count", int'(retire_count), 0);
    endtask

    task automatic t_oldest();
        policy_sel = 2'd2;
        set_status(0, 0, 0, 0); rob_empty = '0;
        set_heads(2, 1, 0, 1, 10, 5, 0, 7);
        run_round("R4 R9 oldest", 4, 1, 3, 0, 0);
        // squashing thread 1 out, fetch-trap thread 3 in, thread 0 empty
        set_status(0, 2, 0, 4); rob_empty = 4'b0001;
        set_heads(1, 1, 0, 1, 1, 2, 0, 9);
        run_round("R4 status and empty", 1, 3, 0, 0, 0);
        set_status(0, 0, 0, 3); rob_empty = '0;
        set_heads(0, 1, 1, 1, 0, 5, 5, 1);
        run_round("R4 tie lowest id, trap excluded", 2, 1, 2, 0, 0);
    endtask

    task automatic t_greedy();
        policy_sel = 2'd0;
        set_status(0, 0, 0, 0); rob_empty = '0;
        set_heads(6, 0, 0, 0, 3, 0, 0, 0);
        run_round("R5 R3 width cap", 4, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check(retire_count == 4, "R3 count held", int'(retire_count), 4);
        set_heads(0, 1, 1, 0, 0, 9, 4, 0);
        run_round("R5 greedy oldest", 2, 2, 1, 0, 0);
    endtask

    task automatic t_rotate();
        policy_sel = 2'd1;
        set_status(0, 0, 0, 0); rob_empty = 4'b1111;
        set_heads(1, 1, 1, 1, 40, 30, 20, 10);
        run_round("R6 R1 ascending list", 4, 0, 1, 2, 3);
        rob_empty = '0;
        set_heads(2, 0, 0, 1, 0, 0, 0, 0);
        run_round("R6 winner to tail", 3, 0, 3, 0, 0);
        // list now 1,2,3,0; thread 0 fetch-trap waiting is excluded
        set_status(4, 0, 0, 0);
        set_heads(1, 0, 1, 0, 0, 0, 0, 0);
        run_round("R6 status filter", 1, 2, 0, 0, 0);
        set_heads(0, 0, 0, 0, 0, 0, 0, 0);
        run_round("R7 no winner", 0, 0, 0, 0, 0);
        // list stays 1,3,0,2
        set_status(0, 0, 0, 0);
        set_heads(1, 1, 1, 1, 0, 0, 0, 0);
        run_round("R7 list persists", 4, 1, 3, 0, 2);
    endtask

    task automatic t_blocked();
        policy_sel = 2'd2;
        set_status(2, 2, 3, 3);
        set_heads(1, 1, 1, 1, 0, 0, 0, 0);
        run_round("R2 nothing eligible", 0, 0, 0, 0, 0);
    endtask

    task automatic single_case(input string req, input int st, input bit emp,
                               input bit rdy, input int n_exp);
        int ng = 0;
        bit finished = 0;
        s_status = 3'(st); s_empty = emp; s_ready = rdy;
        @(negedge clk) s_start = 1'b1;
        @(negedge clk) s_start = 1'b0;
        for (int k = 0; k < 40 && !finished; k++) begin
            @(negedge clk);
            if (s_gv) begin
                ng++;
                check(s_tid == 1'b0, {req, " tid"}, int'(s_tid), 0);
                s_ack = 1'b1;
                @(negedge clk) s_ack = 1'b0;
            end else if (s_done) finished = 1;
        end
        check(finished && ng == n_exp, {req, " grants"}, ng, n_exp);
        check(int'(s_cnt) == n_exp, {req, " count"}, int'(s_cnt), n_exp);
    endtask

    task automatic t_single();
        single_case("R8 running empty ready", 0, 1'b1, 1'b1, 2);
        single_case("R8 fetch-trap ready", 4, 1'b0, 1'b1, 2);
        single_case("R8 squashing", 2, 1'b0, 1'b1, 0);
        single_case("R8 idle not ready", 1, 1'b0, 1'b0, 0);
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin cnt[t] = 0; seqv[t] = 0; end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oldest();
        t_greedy();
        t_rotate();
        t_blocked();
        t_single();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule